// File: doc/BRIEF.md
# Two-Byte Register Access Message Handler

This block sits on the receive and transmit sides of a byte-oriented maintenance channel. It interprets two-byte messages that read or write a small file of seven 8-bit registers. The channel delivers one frame per `frm_valid` pulse. Each frame is either idle or carries a byte value. A byte counts only once the same value has been present for two frames in a row. A complete message is two bytes followed by an idle frame, and it takes effect only when that idle frame arrives.

The low nibble of the first byte selects the operation. A nonzero value is a write to that address, and the second byte is the data. Zero means a read, and the low nibble of the second byte is then the address. A write updates the register and produces a one-clock `wr_ack` pulse with no reply. A read returns a two-byte reply on a valid/ready port. In the busy-reporting mode, a live busy flag replaces bit 3 of both reply bytes. While a reply is still waiting to go out, the handler will not start a new incoming message.

Top module: `regmsg_top`

## Requirements
- R1: An incoming byte is taken only when two consecutive non-idle frames carry the same value. A value present for a single frame is discarded. A byte value held for more than two frames is taken once.
- R2: A message whose first byte has low nibble 1..6 is a write. When the idle frame that follows the second byte arrives, register[nibble] takes the second byte, and `wr_ack` pulses high for exactly one clock. No reply byte is produced.
- R3: A message whose first byte has low nibble 0 is a read of address = low nibble of the second byte (0..6). The reply is two bytes. Reply byte 1 is 0x0 in bits 7:4, 0 in bit 3 and the address in bits 2:0. Reply byte 2 is the register content. Register 0 is read-only and holds the parameter `REG0_VALUE` (default 0x3C). The high nibbles of incoming byte 1 and of a read's byte 2 are ignored.
- R4: When `mode_te` is 1, bit 3 of both reply bytes equals `busy_in`. When `mode_te` is 0, bit 3 of byte 1 is 0 and bit 3 of byte 2 is the content bit.
- R5: A write with low nibble 7..15, or a read whose address nibble is 7..15, changes no register, produces no reply and no `wr_ack`.
- R6: A message is opened only after an idle frame that follows the end of the previous message. The idle frame that completes a message does not also open the next one. A third byte taken before the completing idle discards the whole message.
- R7: An idle frame after only the first byte aborts the message, with no register change, no reply and no `wr_ack`.
- R8: While a reply is pending, incoming bytes are ignored. A new message needs an idle frame after the reply has fully gone out.
- R9: While `rep_valid` is high and `rep_ready` is low, `rep_valid` stays high and the reply byte does not change. The busy bit is the one exception.
- R10: After reset, registers 1..6 are 0 and `rep_valid` and `wr_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-clock strobe per channel frame |
| frm_idle | input | 1 | Frame is idle (no byte) |
| frm_data | input | 8 | Byte value of a non-idle frame |
| mode_te | input | 1 | Busy-reporting mode select |
| busy_in | input | 1 | Busy flag inserted in replies in busy mode |
| rep_valid | output | 1 | Reply byte available |
| rep_data | output | 8 | Reply byte |
| rep_ready | input | 1 | Reply byte accepted on this clock |
| wr_ack | output | 1 | One-clock pulse per committed write |

## Verification
The bench covers the following corner cases:
- **Single-frame glitch before a real byte.** A debouncer that takes single frames would misalign the message and write the wrong register.
- **Third byte before the idle.** A handler that commits early would update a register that must stay unchanged.
- **Message right behind the completing idle.** A handler that lets that idle open the next message would show two acknowledgements.
- **Abort after the first byte.** The bench checks that this leaves no trace.
- **Write sent while a reply is held back.** A handler without reply blocking would acknowledge that write.
- **Out-of-range addresses.** These must produce neither a reply nor an acknowledgement.
- **Busy bit with the flag opposite to the content bit.** This exposes a swapped or missing bit 3 substitution.

// File: rtl/regmsg_pkg.sv
package regmsg_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [1:0] {
    ST_WAIT_IDLE = 2'd0,
    ST_ARMED     = 2'd1,
    ST_HAVE1     = 2'd2,
    ST_HAVE2     = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic                is_wr;
    logic                is_rd;
    logic [NIB_W-1:0]    addr;
  } op_t;
endpackage

// File: rtl/regmsg_debounce.sv
module regmsg_debounce #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frm_valid,
  input  logic         frm_idle,
  input  logic [W-1:0] frm_data,
  output logic         byte_acc
);
  logic [W-1:0] prev_q, prev_d;
  logic         ok_q, ok_d;
  logic         taken_q, taken_d;
  logic         same;

  always_comb begin
    same     = frm_valid && !frm_idle && ok_q && (frm_data == prev_q);
    byte_acc = same && !taken_q;
    prev_d   = prev_q;
    ok_d     = ok_q;
    taken_d  = taken_q;
    if (frm_valid) begin
      if (frm_idle) begin
        ok_d    = 1'b0;
        taken_d = 1'b0;
      end else begin
        prev_d  = frm_data;
        ok_d    = 1'b1;
        taken_d = same;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      ok_q    <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      ok_q    <= ok_d;
      taken_q <= taken_d;
    end
  end
endmodule

// File: rtl/regmsg_seq.sv
module regmsg_seq
  import regmsg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frm_valid,
  input  logic         frm_idle,
  input  logic [W-1:0] frm_data,
  input  logic         byte_acc,
  input  logic         reply_busy,
  output logic         commit,
  output logic [W-1:0] b1,
  output logic [W-1:0] b2,
  output seq_st_t      st
);
  seq_st_t      st_q, st_d;
  logic [W-1:0] b1_q, b1_d, b2_q, b2_d;
  logic         idle_frm;

  always_comb begin
    idle_frm = frm_valid && frm_idle;
    st_d     = st_q;
    b1_d     = b1_q;
    b2_d     = b2_q;
    commit   = 1'b0;
    unique case (st_q)
      ST_WAIT_IDLE: if (idle_frm && !reply_busy) st_d = ST_ARMED;
      ST_ARMED: if (byte_acc) begin
        b1_d = frm_data;
        st_d = ST_HAVE1;
      end
      ST_HAVE1: begin
        if (idle_frm) st_d = ST_ARMED;
        else if (byte_acc) begin
          b2_d = frm_data;
          st_d = ST_HAVE2;
        end
      end
      ST_HAVE2: begin
        if (idle_frm) begin
          commit = 1'b1;
          st_d   = ST_WAIT_IDLE;
        end else if (byte_acc) begin
          st_d = ST_WAIT_IDLE;
        end
      end
      default: st_d = ST_WAIT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT_IDLE;
      b1_q <= '0;
      b2_q <= '0;
    end else begin
      st_q <= st_d;
      b1_q <= b1_d;
      b2_q <= b2_d;
    end
  end

  assign b1 = b1_q;
  assign b2 = b2_q;
  assign st = st_q;
endmodule

// File: rtl/regmsg_regfile.sv
module regmsg_regfile #(
  parameter int             NREG       = 7,
  parameter int             W          = 8,
  parameter logic [W-1:0]   REG0_VALUE = 8'h3C,
  localparam int            AW         = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = REG0_VALUE;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == AW'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/regmsg_reply.sv
module regmsg_reply #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_hdr,
  input  logic [W-1:0] ld_data,
  input  logic         mode_te,
  input  logic         busy_in,
  input  logic         rep_ready,
  output logic         rep_valid,
  output logic [W-1:0] rep_data,
  output logic         pending
);
  logic [1:0]   cnt_q, cnt_d;
  logic [W-1:0] hdr_q, hdr_d, dat_q, dat_d;
  logic [W-1:0] cur;

  always_comb begin
    cnt_d = cnt_q;
    hdr_d = hdr_q;
    dat_d = dat_q;
    if (load) begin
      cnt_d = 2'd2;
      hdr_d = ld_hdr;
      dat_d = ld_data;
    end else if (cnt_q != 2'd0 && rep_ready) begin
      cnt_d = cnt_q - 2'd1;
    end
    cur = (cnt_q == 2'd2) ? hdr_q : dat_q;
    if (mode_te) cur[3] = busy_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      hdr_q <= '0;
      dat_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      hdr_q <= hdr_d;
      dat_q <= dat_d;
    end
  end

  assign rep_valid = (cnt_q != 2'd0);
  assign rep_data  = cur;
  assign pending   = rep_valid;
endmodule

// File: rtl/regmsg_top.sv
module regmsg_top
  import regmsg_pkg::*;
#(
  parameter int                 NREG       = 7,
  parameter logic [BYTE_W-1:0]  REG0_VALUE = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic              frm_idle,
  input  logic [BYTE_W-1:0] frm_data,
  input  logic              mode_te,
  input  logic              busy_in,
  output logic              rep_valid,
  output logic [BYTE_W-1:0] rep_data,
  input  logic              rep_ready,
  output logic              wr_ack
);
  localparam int AW = $clog2(NREG);

  logic [1:0]        rst_sync;
  logic              rst_i;
  logic              byte_acc, commit, reply_busy, ack_q, ack_d;
  logic [BYTE_W-1:0] b1, b2, rdata, hdr;
  seq_st_t           seq_st;
  op_t               op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  regmsg_debounce #(.W(BYTE_W)) u_deb (
    .clk(clk), .rst_n(rst_i), .frm_valid(frm_valid), .frm_idle(frm_idle),
    .frm_data(frm_data), .byte_acc(byte_acc));

  regmsg_seq #(.W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_i), .frm_valid(frm_valid), .frm_idle(frm_idle),
    .frm_data(frm_data), .byte_acc(byte_acc), .reply_busy(reply_busy),
    .commit(commit), .b1(b1), .b2(b2), .st(seq_st));

  always_comb begin
    op.is_wr = (b1[NIB_W-1:0] != '0) && (int'(b1[NIB_W-1:0]) < NREG);
    op.is_rd = (b1[NIB_W-1:0] == '0) && (int'(b2[NIB_W-1:0]) < NREG);
    op.addr  = op.is_rd ? b2[NIB_W-1:0] : b1[NIB_W-1:0];
    hdr      = '0;
    hdr[AW-1:0] = op.addr[AW-1:0];
    ack_d    = commit && op.is_wr;
  end

  regmsg_regfile #(.NREG(NREG), .W(BYTE_W), .REG0_VALUE(REG0_VALUE)) u_rf (
    .clk(clk), .rst_n(rst_i), .we(commit && op.is_wr), .waddr(op.addr[AW-1:0]),
    .wdata(b2), .raddr(op.addr[AW-1:0]), .rdata(rdata));

  regmsg_reply #(.W(BYTE_W)) u_rep (
    .clk(clk), .rst_n(rst_i), .load(commit && op.is_rd), .ld_hdr(hdr),
    .ld_data(rdata), .mode_te(mode_te), .busy_in(busy_in),
    .rep_ready(rep_ready), .rep_valid(rep_valid), .rep_data(rep_data),
    .pending(reply_busy));

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end
  assign wr_ack = ack_q;
endmodule

// File: rtl/regmsg_chk.sv
module regmsg_chk
  import regmsg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rep_valid,
  input logic       rep_ready,
  input logic [7:0] rep_data,
  input logic       wr_ack,
  input logic [1:0] st
);
  // R2: acknowledge lasts one clock
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);

  // R2: a write never starts a reply
  a_r2_no_reply_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && $rose(rep_valid)));

  // R8: sequencer stays closed while a reply is pending
  a_r8_block_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (st == 2'(ST_WAIT_IDLE)));

  // R9: held reply keeps valid and its bits (bit 3 may follow busy)
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> rep_valid);

  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> $stable({rep_data[7:4], rep_data[2:0]}));
endmodule

bind regmsg_top regmsg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_ready(rep_ready),
  .rep_data(rep_data), .wr_ack(wr_ack), .st(seq_st));

// File: tb/tb_regmsg_top.sv
module tb_regmsg_top;
  localparam logic [7:0] REG0 = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0, frm_idle = 1'b1;
  logic [7:0] frm_data = 8'h00;
  logic       mode_te = 1'b0, busy_in = 1'b0, rep_ready = 1'b1;
  logic       rep_valid, wr_ack;
  logic [7:0] rep_data;

  int tests = 0, fails = 0;
  int ack_n = 0, cap_n = 0;
  logic [7:0] cap [4];
  logic [7:0] model [7];
  logic mon_en = 1'b0;

  always #4 clk = ~clk;

  regmsg_top dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_idle(frm_idle),
    .frm_data(frm_data), .mode_te(mode_te), .busy_in(busy_in),
    .rep_valid(rep_valid), .rep_data(rep_data), .rep_ready(rep_ready),
    .wr_ack(wr_ack));

  always @(negedge clk) if (mon_en) begin
    if (wr_ack) ack_n++;
    if (rep_valid && rep_ready) begin
      if (cap_n < 4) cap[cap_n] = rep_data;
      cap_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] exp_hdr(input int a, input logic te, input logic bz);
    logic [7:0] h;
    h = 8'(a);
    h[3] = te ? bz : 1'b0;
    return h;
  endfunction

  function automatic logic [7:0] exp_dat(input logic [7:0] c, input logic te, input logic bz);
    logic [7:0] d;
    d = c;
    if (te) d[3] = bz;
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic idl, input logic [7:0] d);
    @(negedge clk);
    frm_valid = 1'b1; frm_idle = idl; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) frame(1'b1, 8'h00);
  endtask

  task automatic sbyte(input logic [7:0] b);
    frame(1'b0, b); frame(1'b0, b);
  endtask

  task automatic clr();
    ack_n = 0; cap_n = 0;
  endtask

  task automatic message(input logic [7:0] b1, input logic [7:0] b2);
    idles(1); sbyte(b1); sbyte(b2); idles(3);
  endtask

  task automatic do_read(input string req, input int a, input logic te, input logic bz);
    logic [7:0] b1, b2;
    b1 = {4'($urandom), 4'h0};
    b2 = {4'($urandom), 4'(a)};
    if (b1 == b2) b2[7:4] = b2[7:4] + 4'h1;
    mode_te = te; busy_in = bz;
    clr(); message(b1, b2);
    check({req, " reply count"}, cap_n, 2);
    check({req, " reply hdr"}, cap[0], exp_hdr(a, te, bz));
    check({req, " reply data"}, cap[1], exp_dat(model[a], te, bz));
    check({req, " no ack on read"}, ack_n, 0);
  endtask

  task automatic do_write(input string req, input int a, input logic [7:0] d);
    logic [7:0] b1, dd;
    b1 = {4'($urandom), 4'(a)};
    dd = d;
    if (dd == b1) dd = dd ^ 8'h80;
    clr(); message(b1, dd);
    check({req, " ack count"}, ack_n, 1);
    check({req, " no reply"}, cap_n, 0);
    model[a] = dd;
  endtask

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    model[0] = REG0;
    for (int i = 1; i < 7; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;

    // R10 reset state
    check("R10 rep_valid", rep_valid, 0);
    check("R10 wr_ack", wr_ack, 0);
    do_read("R10 reg2 zero", 2, 1'b0, 1'b0);
    do_read("R3 reg0 constant", 0, 1'b0, 1'b0);

    // R2/R3 write then read
    do_write("R2 write reg5", 5, 8'hC8);
    do_read("R3 read reg5", 5, 1'b0, 1'b1);
    // R4 busy insertion, flag opposite to content bit 3
    do_read("R4 busy=1", 5, 1'b1, 1'b1);
    do_read("R4 busy=0", 5, 1'b1, 1'b0);
    do_read("R4 reg0 busy=0", 0, 1'b1, 1'b0);

    // R1 glitch frame before a real byte
    clr(); idles(1); frame(1'b0, 8'h06); sbyte(8'h03); sbyte(8'h5A);
    frame(1'b0, 8'h5A); idles(3);
    check("R1 glitch ack", ack_n, 1);
    model[3] = 8'h5A;
    do_read("R1 reg3 written", 3, 1'b0, 1'b0);
    do_read("R1 reg6 untouched", 6, 1'b0, 1'b0);

    // R5 out of range
    clr(); message(8'h07, 8'h11);
    check("R5 write addr7 ack", ack_n, 0);
    check("R5 write addr7 reply", cap_n, 0);
    clr(); message(8'h2F, 8'h22);
    check("R5 write addrF ack", ack_n, 0);
    clr(); message(8'h00, 8'h07);
    check("R5 read addr7 reply", cap_n, 0);
    check("R5 read addr7 ack", ack_n, 0);

    // R7 abort after first byte
    clr(); idles(1); sbyte(8'h04); idles(3);
    check("R7 abort ack", ack_n, 0);
    do_read("R7 reg4 unchanged", 4, 1'b0, 1'b0);

    // R6 third byte before idle
    clr(); idles(1); sbyte(8'h02); sbyte(8'h77); sbyte(8'h99); idles(3);
    check("R6 concat ack", ack_n, 0);
    check("R6 concat reply", cap_n, 0);
    do_read("R6 reg2 unchanged", 2, 1'b0, 1'b0);

    // R6 completing idle does not open the next message
    clr(); idles(1); sbyte(8'h01); sbyte(8'h11); idles(1);
    sbyte(8'h02); sbyte(8'h22); idles(3);
    check("R6 no reopen ack", ack_n, 1);
    model[1] = 8'h11;
    do_read("R6 reg1 written", 1, 1'b0, 1'b0);
    do_read("R6 reg2 still", 2, 1'b0, 1'b0);

    // R8/R9 reply held back, write attempted meanwhile
    rep_ready = 1'b0; mode_te = 1'b0;
    clr(); message(8'h00, 8'h05);
    check("R9 valid held", rep_valid, 1);
    held = rep_data;
    idles(1); sbyte(8'h03); sbyte(8'h44); idles(3);
    check("R9 data held", rep_data, held);
    check("R8 blocked write ack", ack_n, 0);
    @(negedge clk); rep_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 late reply count", cap_n, 2);
    check("R8 late reply hdr", cap[0], exp_hdr(5, 1'b0, 1'b0));
    check("R8 late reply data", cap[1], model[5]);
    do_read("R8 reg3 unchanged", 3, 1'b0, 1'b0);

    // random mix, R2 R3 R4
    for (int k = 0; k < 50; k++) begin
      if ($urandom_range(0, 1) == 0)
        do_write("R2 random write", int'($urandom_range(1, 6)), 8'($urandom));
      else
        do_read("R3 random read", int'($urandom_range(0, 6)),
                1'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule